// File: doc/BRIEF.md
# Center-Aligned Three-Phase PWM Generator

This block drives the six gate signals of a three-phase inverter bridge. Each phase has a high-side output and a low-side output. A 16-bit counter runs up and then back down. Its half-period comes from a programmable register, and the full switching period lasts twice that many clock cycles. Each phase compares the counter against a threshold derived from a signed duty value. Because the counter is symmetric, the resulting pulses are centred on the midpoint of the period.

Software writes the period and the three duty values into holding registers. These are copied into the working registers at the start of each period. In double-update mode the duty values are also copied at the midpoint, so the two halves of a pulse can differ. A programmable dead time trims every edge of both outputs of a phase, so the two outputs of a phase never conduct together. The block marks the start of each period with a one-cycle pulse, and it can restart the period on an external pulse instead. Each output has its own polarity bit.

An active-low trip input turns all six outputs off through combinational logic, without waiting for a clock edge. It also sets a sticky flag that keeps the outputs off until software clears it.

Top module: `pwm3_center`

## Requirements
- R1: The counter state sequence is 0,1,…,H-1,H-1,…,1,0, giving a period of exactly 2·H clock cycles. H is the active half-period, and a written value of 0 is used as 1. `sync_out` is high for one cycle at the first state of every period. After reset, H is the parameter DEF_HALF.
- R2: Let T = ceil(H/2) − D, where D is the signed active duty of a phase and v is the counter value of a cycle. The phase's high-side output is active when v ≥ T + DT, and its low-side output is active when v < T − DT. DT is the dead time. Each output registers its state one cycle after the counter state it was computed from.
- R3: In single-update mode (control bit 0 = 0), writes to the period register (address 0) and the duty registers (addresses 1, 2 and 3 for phases A, B and C) take effect only at the next period start. Pulses are therefore symmetric about the midpoint.
- R4: In double-update mode (control bit 0 = 1), duty values are also loaded when the counter turns from counting up to counting down. A duty write made during the rising half shapes the falling half of the same period.
- R5: The dead time register (address 4, unsigned, effective immediately) shortens the pulses of both outputs by DT counter steps at each edge. A pulse that would become narrower than 2·DT vanishes. The high-side and low-side outputs of a phase are never active together.
- R6: Duty values are two's complement. Any value at or beyond the positive limit (T + DT ≤ 0) holds the high side on for the whole period. Any value at or beyond the negative limit holds the low side on for the whole period. No transitions occur in either case.
- R7: When control bit 1 = 1, a high `sync_in` at a clock edge restarts the period: the counter goes to 0, the period and duty registers load, and `sync_out` is high in the next cycle. When the bit is 0, `sync_in` is ignored.
- R8: Control bits 4:2 invert the high-side pins of phases A, B and C, and bits 7:5 invert the low-side pins. A set bit makes that pin active-low, and its off level is 1.
- R9: While `trip_n` is low, all six pins are at their off level. This happens as soon as `trip_n` falls, with no clock edge needed.
- R10: A low `trip_n` sets `trip_flag`. The flag and the forced-off state stay in place after `trip_n` returns high. Both are cleared only by writing 1 in bit 0 to address 6 while `trip_n` is high.
- R11: After reset, all pins are low (polarity bits 0), `trip_flag` is 0, and the duty and dead time values are 0.
- R12: Register writes use `wr_en`, `wr_addr` and `wr_data`. The control register is at address 5 and holds 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| sync_in | input | 1 | External period restart pulse |
| trip_n | input | 1 | Asynchronous active-low trip |
| sync_out | output | 1 | One-cycle pulse at each period start |
| pwm_hi | output | 3 | High-side pins, bit 0 = phase A |
| pwm_lo | output | 3 | Low-side pins, bit 0 = phase A |
| trip_flag | output | 1 | Sticky trip status |

## Verification
The assertions check the following on every cycle:
- The counter stays below the active half-period.
- The working period and duties change only at the update points.
- The two outputs of a phase never overlap.
- Pins sit at their off level whenever the trip is low.
- The trip flag follows a low trip.
- The period-start pulse never lasts two cycles unless a restart occurs.

Other behaviours can only be shown by the bench's scenarios, which compare every cycle of whole periods against waveforms computed from the threshold rule. These behaviours are:
- the exact pulse shapes under dead time, saturation and polarity;
- the delayed effect of writes in single-update mode;
- the asymmetric halves in double-update mode;
- restart by the external pulse;
- the immediate, unclocked trip response and the sticky recovery.

// File: rtl/pwm3_center.sv
module pwm3_center #(
  parameter int CW       = 16,
  parameter int AW       = 3,
  parameter int DEF_HALF = 50
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic          sync_in,
  input  logic          trip_n,
  output logic          sync_out,
  output logic [2:0]    pwm_hi,
  output logic [2:0]    pwm_lo,
  output logic          trip_flag
);

  localparam int TW = CW + 3;
  localparam int A_PER = 0, A_DUTY0 = 1, A_DEAD = 4, A_CTRL = 5, A_CLR = 6;
  localparam logic [CW-1:0] DEF_H = CW'(DEF_HALF);

  logic [CW-1:0]        per_sh, per_act, dead, cnt;
  logic [2:0][CW-1:0]   duty_sh, duty_act;
  logic [7:0]           ctrl;
  logic                 up, tripped;
  logic [2:0]           on_h, on_l, raw_h, raw_l;
  logic                 restart, at_top, at_bottom, load_start, load_mid, gate;
  logic [TW-1:0]        half_ceil;
  logic signed [TW-1:0] cnt_s, dead_s;

  assign restart    = sync_in & ctrl[1];
  assign at_top     = up && (cnt == per_act - CW'(1));
  assign at_bottom  = !up && (cnt == '0);
  assign load_start = restart | at_bottom;
  assign load_mid   = at_top & ctrl[0] & ~restart;
  assign sync_out   = up && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      per_sh  <= DEF_H;
      duty_sh <= '0;
      dead    <= '0;
      ctrl    <= '0;
    end else if (wr_en) begin
      if (wr_addr == AW'(A_PER))  per_sh <= wr_data;
      if (wr_addr == AW'(A_DEAD)) dead   <= wr_data;
      if (wr_addr == AW'(A_CTRL)) ctrl   <= wr_data[7:0];
      for (int i = 0; i < 3; i++)
        if (wr_addr == AW'(A_DUTY0 + i)) duty_sh[i] <= wr_data;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0;
      up  <= 1'b1;
    end else if (restart) begin
      cnt <= '0;
      up  <= 1'b1;
    end else if (up) begin
      if (at_top) up <= 1'b0;
      else        cnt <= cnt + CW'(1);
    end else begin
      if (at_bottom) up <= 1'b1;
      else           cnt <= cnt - CW'(1);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      per_act  <= DEF_H;
      duty_act <= '0;
    end else if (load_start) begin
      per_act  <= (per_sh == '0) ? CW'(1) : per_sh;
      duty_act <= duty_sh;
    end else if (load_mid) begin
      duty_act <= duty_sh;
    end

  assign half_ceil = ({3'b000, per_act} + TW'(1)) >> 1;
  assign cnt_s     = $signed({3'b000, cnt});
  assign dead_s    = $signed({3'b000, dead});

  always_comb
    for (int i = 0; i < 3; i++) begin
      logic signed [TW-1:0] th;
      th       = $signed(half_ceil) - $signed({{3{duty_act[i][CW-1]}}, duty_act[i]});
      raw_h[i] = cnt_s >= th + dead_s;
      raw_l[i] = cnt_s < th - dead_s;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      on_h <= '0;
      on_l <= '0;
    end else begin
      on_h <= raw_h;
      on_l <= raw_l;
    end

  always_ff @(posedge clk or negedge rst_n or negedge trip_n)
    if (!rst_n)       tripped <= 1'b0;
    else if (!trip_n) tripped <= 1'b1;
    else if (wr_en && wr_addr == AW'(A_CLR) && wr_data[0]) tripped <= 1'b0;

  assign gate      = trip_n & ~tripped;
  assign trip_flag = tripped;
  assign pwm_hi    = (on_h & {3{gate}}) ^ ctrl[4:2];
  assign pwm_lo    = (on_l & {3{gate}}) ^ ctrl[7:5];

  a_r1_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < per_act);
  a_r1_period_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load_start |=> $stable(per_act));
  a_r3_duty_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_start && !load_mid) |=> $stable(duty_act));
  a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    (on_h & on_l) == 3'b000);
  a_r7_sync_single: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_out && !restart) |=> !sync_out);
  a_r9_trip_off: assert property (@(posedge clk) disable iff (!rst_n)
    !trip_n |-> (pwm_hi == ctrl[4:2] && pwm_lo == ctrl[7:5]));
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !trip_n |=> trip_flag);

endmodule

// File: tb/pwm3_center_tb_top.sv
`timescale 1ns/1ps
module pwm3_center_tb_top;
  localparam int DEF_HALF = 50;

  logic clk = 0, rst_n = 0, wr_en = 0, sync_in = 0, trip_n = 1;
  logic [2:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic sync_out, trip_flag;
  logic [2:0] pwm_hi, pwm_lo;

  int checks = 0, failures = 0;
  int H, DT;
  int eu[3], ed[3];
  logic [2:0] ph, pl;

  always #2 clk = ~clk;

  pwm3_center #(.CW(16), .AW(3), .DEF_HALF(DEF_HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sync_in(sync_in), .trip_n(trip_n), .sync_out(sync_out),
    .pwm_hi(pwm_hi), .pwm_lo(pwm_lo), .trip_flag(trip_flag));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R12: one register write, entered and left at a falling edge
  task automatic wr(input int addr, input int data);
    wr_addr = 3'(addr);
    wr_data = 16'(data);
    wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wait_sync();
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!sync_out && n < 2000);
  endtask

  function automatic int th_of(input int d);
    return (H + 1) / 2 - d;
  endfunction

  // Compares every cycle of one period, starting at a falling edge where sync_out is high
  task automatic measure(input string tag, input bit mid, input int mid_val);
    int mh[3], ml[3];
    int ms = 0;
    for (int i = 0; i < 3; i++) begin mh[i] = 0; ml[i] = 0; end
    if (mid) begin wr_addr = 3'd1; wr_data = 16'(mid_val); wr_en = 1; end
    for (int s = 0; s < 2 * H; s++) begin
      int v;
      @(negedge clk);
      wr_en = 0;
      v = (s < H) ? s : 2 * H - 1 - s;
      for (int i = 0; i < 3; i++) begin
        int th;
        bit eh, el;
        th = th_of((s < H) ? eu[i] : ed[i]);
        eh = (v >= th + DT);
        el = (v < th - DT);
        if (pwm_hi[i] !== (eh ^ ph[i])) mh[i]++;
        if (pwm_lo[i] !== (el ^ pl[i])) ml[i]++;
      end
      if (sync_out !== (s == 2 * H - 1)) ms++;
    end
    for (int i = 0; i < 3; i++) begin
      check(mh[i] == 0, $sformatf("%s phase %0d high-side cycle mismatches", tag, i), mh[i], 0);
      check(ml[i] == 0, $sformatf("%s phase %0d low-side cycle mismatches", tag, i), ml[i], 0);
    end
    check(ms == 0, $sformatf("%s R1 sync_out timing mismatches", tag), ms, 0);
  endtask

  task automatic setup(input int h, input int dt, input int ctl, input int a, input int b, input int c);
    H = h; DT = dt;
    ph = 3'(ctl >> 2); pl = 3'(ctl >> 5);
    wr(0, h); wr(4, dt); wr(5, ctl); wr(1, a); wr(2, b); wr(3, c);
    eu[0] = a; eu[1] = b; eu[2] = c;
    ed = eu;
    wait_sync();
    wait_sync();
  endtask

  task automatic t_reset();
    int n = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    #1;
    check(pwm_hi == 3'b000 && pwm_lo == 3'b000, "R11 pins low after reset", {pwm_hi, pwm_lo}, 0);
    check(trip_flag == 0, "R11 trip_flag clear after reset", trip_flag, 0);
    check(sync_out == 1, "R1 first state is period start", sync_out, 1);
    do begin @(negedge clk); n++; end while (!sync_out && n < 1000);
    check(n == 2 * DEF_HALF, "R1 default period length", n, 2 * DEF_HALF);
  endtask

  task automatic t_basic();
    setup(16, 0, 0, 0, 3, -5);
    measure("R2 basic", 0, 0);
    setup(11, 0, 0, 2, -1, 4);
    measure("R2 odd period R3 period update", 0, 0);
  endtask

  task automatic t_dead();
    // R5: phase C raw pulse is 2 cycles, below 2*DT, so its high side must vanish
    setup(16, 2, 0, 0, 3, -7);
    measure("R5 dead time", 0, 0);
  endtask

  task automatic t_sat();
    setup(16, 0, 0, 8, -32768, 32767);
    measure("R6 saturation", 0, 0);
    setup(16, 3, 0, 30000, -30000, 11);
    measure("R6 saturation with dead time", 0, 0);
  endtask

  task automatic t_single();
    setup(16, 0, 0, 0, 0, 0);
    measure("R3 mid write held", 1, 4);
    wait_sync();
    eu[0] = 4; ed[0] = 4;
    measure("R3 write applied next period", 0, 0);
  endtask

  task automatic t_double();
    setup(16, 0, 1, 0, 2, -2);
    ed[0] = 5;
    measure("R4 asymmetric halves", 1, 5);
    wait_sync();
    eu[0] = 5;
    measure("R4 both halves after update", 0, 0);
  endtask

  task automatic t_pol();
    setup(16, 1, 8'hFC, 2, -3, 0);
    measure("R8 active-low pins", 0, 0);
    setup(16, 1, 8'b101_010_00, 2, -3, 0);
    measure("R8 mixed polarity", 0, 0);
  endtask

  task automatic t_sync();
    int n = 0;
    setup(16, 0, 0, 0, 0, 0);
    repeat (5) @(negedge clk);
    sync_in = 1;
    @(negedge clk);
    sync_in = 0;
    check(sync_out == 0, "R7 sync_in ignored when disabled", sync_out, 0);
    setup(16, 0, 2, 0, 0, 0);
    repeat (5) @(negedge clk);
    sync_in = 1;
    @(negedge clk);
    sync_in = 0;
    check(sync_out == 1, "R7 external restart starts period", sync_out, 1);
    do begin @(negedge clk); n++; end while (!sync_out && n < 1000);
    check(n == 2 * H, "R7 full period after restart", n, 2 * H);
  endtask

  task automatic t_trip();
    int on = 0;
    setup(16, 0, 0, 3, 3, 3);
    repeat (3) @(negedge clk);
    check((pwm_hi | pwm_lo) != 3'b000, "R9 pins active before trip", {pwm_hi, pwm_lo}, 1);
    trip_n = 0;
    #1;
    check(pwm_hi == 3'b000 && pwm_lo == 3'b000, "R9 unclocked trip forces off", {pwm_hi, pwm_lo}, 0);
    @(negedge clk);
    check(trip_flag == 1, "R10 trip_flag set", trip_flag, 1);
    wr(6, 1);
    check(trip_flag == 1, "R10 clear ignored while trip low", trip_flag, 1);
    trip_n = 1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if ((pwm_hi | pwm_lo) != 3'b000) on++;
    end
    check(on == 0, "R10 outputs stay off until cleared", on, 0);
    check(trip_flag == 1, "R10 flag sticky after trip release", trip_flag, 1);
    wr(6, 1);
    check(trip_flag == 0, "R10 flag cleared by write", trip_flag, 0);
    wait_sync();
    measure("R10 recovery after clear", 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_dead();
    t_sat();
    t_single();
    t_double();
    t_pol();
    t_sync();
    t_trip();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule